// File: doc/BRIEF.md
# Expansion Window Address Decoder

This block sits between a CPU bus and the devices on a 64 KB expansion-board window. It routes each access to one of four targets: a boot ROM in the lower 32 KB, a SCSI controller port, a two-channel IDE register file, or a read-only configuration/status byte. The incoming request is registered, and every select, address, write-data and read-response output is then driven combinationally from that registered phase. Read data from the ROM, the SCSI port and the IDE file arrives on plain inputs within the same cycle as the select.

Requests use a valid/ready handshake. A request is taken on a rising edge where `bus_valid` and `bus_ready` are both high. `bus_ready` is high when no access is in progress, or when the access in progress is on its final beat. A 16-bit access to the IDE data register moves as one beat. Any other 16-bit access becomes two byte beats: the even address first, then the odd one. `bus_ready` is low during the first of those two beats. A requester may hold `bus_valid` with stable fields for as long as `bus_ready` stays low. The read response (`rsp_valid`, `rsp_data`) is a single-cycle pulse on the final beat and cannot be stalled.

Top module: `exp_window_decoder`

## Requirements
- R1: An address with bit 15 clear reads the ROM. `sel_rom` is high and `rom_addr` is the beat address masked to ROM_AW bits. The response byte is `rom_byte`.
- R2: An address whose bits 15,10,9,8 are 1,0,0,0 or 1,1,0,0 selects the SCSI port (`sel_scsi`) for both reads and writes. The read byte is `scsi_rdata`.
- R3: An address whose bits 15,10,9,8 are 1,0,0,1 and whose bit 0 is 0 selects the IDE file (`sel_ide`). `ide_reg` equals address bits 4:2 and `ide_chan` equals address bit 13. The same window with bit 0 set selects nothing and reads 0xFF.
- R4: An address whose bits 15,10,9,8 are 1,0,1,1 reads the status byte. Bits 2:0 are `cfg_dev_id` XOR 7, bit 3 is NOT `cfg_opt0`, bit 5 is `cfg_autoboot_en`, and bits 4 and 6 are 0.
- R5: Status bit 7 follows `ide0_irq OR ide0_drq` live, in the cycle the status byte is read.
- R6: Writes to the ROM region or the status window assert no select and change no read-back.
- R7: A read from any other address in the upper half returns 0xFF with no select asserted.
- R8: A 16-bit access to IDE register index 0 at an even address is one beat with `out_word` high. Write data passes on all 16 bits, and the response is all 16 bits of `ide_rdata`.
- R9: Any other 16-bit access is two byte beats, at the even address and then the odd address. Write data goes high byte first on `out_wdata[7:0]`. The response is {first byte, second byte}.
- R10: A 16-bit ROM read returns the byte at the even address as the high byte and the next byte as the low byte.
- R11: At most one select is high at a time, and every select is low while no access is in progress. `bus_ready` is low only during the first beat of a split access.
- R12: After reset, all selects and `rsp_valid` are low and `bus_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted this edge when high with bus_valid |
| bus_addr | input | 16 | Byte address within the window |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| sel_rom | output | 1 | ROM read select |
| sel_scsi | output | 1 | SCSI port select |
| sel_ide | output | 1 | IDE register select |
| sel_stat | output | 1 | Status byte read select |
| out_addr | output | 16 | Byte address of the current beat |
| out_write | output | 1 | Current beat is a write |
| out_word | output | 1 | Current beat is a whole 16-bit IDE data transfer |
| out_wdata | output | 16 | Beat write data (bits 7:0 for byte beats) |
| ide_reg | output | 3 | IDE register index |
| ide_chan | output | 1 | IDE channel, 1 = secondary |
| rom_addr | output | ROM_AW | ROM byte index |
| rom_byte | input | 8 | ROM byte at rom_addr |
| scsi_rdata | input | 8 | SCSI port read byte |
| ide_rdata | input | 16 | IDE read data (byte reads use bits 7:0) |
| cfg_dev_id | input | 3 | Device ID jumpers |
| cfg_autoboot_en | input | 1 | Autoboot enabled |
| cfg_opt0 | input | 1 | Configuration option bit 0 |
| ide0_irq | input | 1 | IDE channel 0 interrupt |
| ide0_drq | input | 1 | IDE channel 0 data request |
| rsp_valid | output | 1 | Read response on the final beat |
| rsp_data | output | 16 | Read response data |

## Verification
The bench builds the block with the default ROM_AW of 15, which maps the whole lower half of the window onto the ROM. With that setting, bit 15 is the only thing separating the ROM from the decoded upper half, and no ROM index can alias into it. Random addresses are weighted toward each window. Odd addresses in the IDE window reach the case where the second beat of a split word selects nothing. Back-to-back requests exercise acceptance on a final beat.

// File: rtl/ewd_pkg.sv
package ewd_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ROM,
    TGT_SCSI,
    TGT_IDE,
    TGT_STAT
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [2:0] reg_idx;
    logic       chan;
  } dec_t;

  localparam int unsigned WIN_AW = 16;
  localparam logic [7:0]  FILL_BYTE = 8'hFF;
endpackage

// File: rtl/ewd_decode.sv
module ewd_decode
  import ewd_pkg::*;
(
  input  logic       a_hi,
  input  logic [2:0] a_sub,
  input  logic       a_chan,
  input  logic [2:0] a_idx,
  input  logic       a_odd,
  output dec_t       dec
);
  always_comb begin
    dec.tgt     = TGT_NONE;
    dec.reg_idx = a_idx;
    dec.chan    = a_chan;
    if (!a_hi) begin
      dec.tgt = TGT_ROM;
    end else begin
      unique case (a_sub)
        3'b000, 3'b100: dec.tgt = TGT_SCSI;
        3'b001:         dec.tgt = a_odd ? TGT_NONE : TGT_IDE;
        3'b011:         dec.tgt = TGT_STAT;
        default:        dec.tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ewd_status.sv
module ewd_status (
  input  logic [2:0] dev_id,
  input  logic       autoboot_en,
  input  logic       opt0,
  input  logic       irq,
  input  logic       drq,
  output logic [7:0] stat
);
  always_comb begin
    stat      = 8'h00;
    stat[2:0] = dev_id ^ 3'b111;
    stat[3]   = ~opt0;
    stat[5]   = autoboot_en;
    stat[7]   = irq | drq;
  end
endmodule

// File: rtl/ewd_beat_seq.sv
module ewd_beat_seq #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [15:0]   req_wdata,
  input  logic          last,
  input  logic [7:0]    cur_byte,
  output logic          act,
  output logic          beat,
  output logic [AW-1:0] beat_addr,
  output logic          ph_write,
  output logic          ph_word,
  output logic [15:0]   ph_wdata,
  output logic [7:0]    hi_byte
);
  logic [AW-1:0] ph_addr;

  assign req_ready = !act || last;
  assign beat_addr = {ph_addr[AW-1:1], ph_word ? beat : ph_addr[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      beat     <= 1'b0;
      ph_addr  <= '0;
      ph_write <= 1'b0;
      ph_word  <= 1'b0;
      ph_wdata <= '0;
      hi_byte  <= '0;
    end else if (req_valid && req_ready) begin
      act      <= 1'b1;
      beat     <= 1'b0;
      ph_addr  <= req_addr;
      ph_write <= req_write;
      ph_word  <= req_word;
      ph_wdata <= req_wdata;
    end else if (act) begin
      if (last) begin
        act <= 1'b0;
      end else begin
        beat    <= 1'b1;
        hi_byte <= cur_byte;
      end
    end
  end
endmodule

// File: rtl/exp_window_decoder.sv
module exp_window_decoder
  import ewd_pkg::*;
#(
  parameter int unsigned ROM_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [15:0]       bus_addr,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic [15:0]       bus_wdata,
  output logic              sel_rom,
  output logic              sel_scsi,
  output logic              sel_ide,
  output logic              sel_stat,
  output logic [15:0]       out_addr,
  output logic              out_write,
  output logic              out_word,
  output logic [15:0]       out_wdata,
  output logic [2:0]        ide_reg,
  output logic              ide_chan,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_byte,
  input  logic [7:0]        scsi_rdata,
  input  logic [15:0]       ide_rdata,
  input  logic [2:0]        cfg_dev_id,
  input  logic              cfg_autoboot_en,
  input  logic              cfg_opt0,
  input  logic              ide0_irq,
  input  logic              ide0_drq,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data
);
  localparam int unsigned AW = WIN_AW;

  logic          act, beat, ph_write, ph_word, last, pass;
  logic [AW-1:0] beat_addr;
  logic [15:0]   ph_wdata;
  logic [7:0]    hi_byte, cur_byte, stat_byte;
  dec_t          bdec;

  ewd_beat_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (bus_valid),
    .req_ready (bus_ready),
    .req_addr  (bus_addr),
    .req_write (bus_write),
    .req_word  (bus_word),
    .req_wdata (bus_wdata),
    .last      (last),
    .cur_byte  (cur_byte),
    .act       (act),
    .beat      (beat),
    .beat_addr (beat_addr),
    .ph_write  (ph_write),
    .ph_word   (ph_word),
    .ph_wdata  (ph_wdata),
    .hi_byte   (hi_byte)
  );

  ewd_decode u_dec (
    .a_hi   (beat_addr[15]),
    .a_sub  (beat_addr[10:8]),
    .a_chan (beat_addr[13]),
    .a_idx  (beat_addr[4:2]),
    .a_odd  (beat_addr[0]),
    .dec    (bdec)
  );

  ewd_status u_stat (
    .dev_id      (cfg_dev_id),
    .autoboot_en (cfg_autoboot_en),
    .opt0        (cfg_opt0),
    .irq         (ide0_irq),
    .drq         (ide0_drq),
    .stat        (stat_byte)
  );

  // Whole-word transfer only for the IDE data register; it ends the access.
  assign pass = ph_word && (bdec.tgt == TGT_IDE) && (bdec.reg_idx == 3'd0);
  assign last = !ph_word || pass || beat;

  assign sel_rom  = act && (bdec.tgt == TGT_ROM)  && !ph_write;
  assign sel_scsi = act && (bdec.tgt == TGT_SCSI);
  assign sel_ide  = act && (bdec.tgt == TGT_IDE);
  assign sel_stat = act && (bdec.tgt == TGT_STAT) && !ph_write;

  assign out_addr  = beat_addr;
  assign out_write = act && ph_write;
  assign out_word  = act && pass;
  assign ide_reg   = sel_ide ? bdec.reg_idx : 3'd0;
  assign ide_chan  = sel_ide && bdec.chan;
  assign rom_addr  = beat_addr[ROM_AW-1:0];

  always_comb begin
    unique case (bdec.tgt)
      TGT_ROM:  cur_byte = rom_byte;
      TGT_SCSI: cur_byte = scsi_rdata;
      TGT_IDE:  cur_byte = ide_rdata[7:0];
      TGT_STAT: cur_byte = stat_byte;
      default:  cur_byte = FILL_BYTE;
    endcase
  end

  always_comb begin
    if (pass)
      out_wdata = ph_wdata;
    else if (ph_word && !beat)
      out_wdata = {8'h00, ph_wdata[15:8]};
    else
      out_wdata = {8'h00, ph_wdata[7:0]};
  end

  assign rsp_valid = act && last && !ph_write;
  always_comb begin
    if (pass)
      rsp_data = ide_rdata;
    else if (ph_word)
      rsp_data = {hi_byte, cur_byte};
    else
      rsp_data = {8'h00, cur_byte};
  end
endmodule

// File: rtl/ewd_checker.sv
module ewd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ready,
  input logic        sel_rom,
  input logic        sel_scsi,
  input logic        sel_ide,
  input logic        sel_stat,
  input logic [15:0] out_addr,
  input logic        out_write,
  input logic        out_word,
  input logic [2:0]  ide_reg,
  input logic        ide0_irq,
  input logic        ide0_drq,
  input logic [15:0] rsp_data
);
  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_rom, sel_scsi, sel_ide, sel_stat}));

  p_no_double_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> bus_ready);

  p_ro_targets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rom || sel_stat) |-> !out_write);

  p_rom_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rom |-> !out_addr[15]);

  p_ide_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ide |-> (out_addr[15] && out_addr[10:8] == 3'b001 && !out_addr[0]));

  p_stat_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stat |-> (rsp_data[7] == (ide0_irq || ide0_drq)));

  p_pass_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_word |-> (sel_ide && ide_reg == 3'd0));
endmodule

bind exp_window_decoder ewd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ready (bus_ready),
  .sel_rom   (sel_rom),
  .sel_scsi  (sel_scsi),
  .sel_ide   (sel_ide),
  .sel_stat  (sel_stat),
  .out_addr  (out_addr),
  .out_write (out_write),
  .out_word  (out_word),
  .ide_reg   (ide_reg),
  .ide0_irq  (ide0_irq),
  .ide0_drq  (ide0_drq),
  .rsp_data  (rsp_data)
);

// File: tb/exp_window_decoder_tb.sv
module exp_window_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic bus_ready, sel_rom, sel_scsi, sel_ide, sel_stat, out_write, out_word, ide_chan;
  logic rsp_valid;
  logic [15:0] out_addr, out_wdata, rsp_data, ide_rdata;
  logic [2:0] ide_reg;
  logic [ROM_AW-1:0] rom_addr;
  logic [7:0] rom_byte, scsi_rdata;
  logic [2:0] cfg_dev_id = 3'd0;
  logic cfg_autoboot_en = 1'b0, cfg_opt0 = 1'b0, ide0_irq = 1'b0, ide0_drq = 1'b0;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_model(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] scsi_model(input logic [15:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction
  function automatic logic [15:0] ide_model(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C};
  endfunction

  assign rom_byte   = rom_model(rom_addr);
  assign scsi_rdata = scsi_model(out_addr);
  assign ide_rdata  = ide_model(out_addr);

  exp_window_decoder #(.ROM_AW(ROM_AW)) u_dut (.*);

  // 0 none, 1 rom, 2 scsi, 3 ide, 4 status
  function automatic int kind(input logic [15:0] a);
    logic [15:0] m = a & 16'h8700;
    if (!a[15]) return 1;
    if (m == 16'h8000 || m == 16'h8400) return 2;
    if (m == 16'h8100) return ((a & 16'h8001) == 16'h8000) ? 3 : 0;
    if (m == 16'h8300) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] stat_model();
    logic [7:0] s = 8'h00;
    s[2:0] = cfg_dev_id ^ 3'd7;
    if (!cfg_opt0) s[3] = 1'b1;
    if (cfg_autoboot_en) s[5] = 1'b1;
    if (ide0_irq || ide0_drq) s[7] = 1'b1;
    return s;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    case (kind(a))
      1: return rom_model(a[14:0]);
      2: return scsi_model(a);
      3: return ide_model(a)[7:0];
      4: return stat_model();
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a, input logic wr, input logic wd, input logic pass);
    int k = kind(a);
    if (pass) return "R8";
    if (wr && (k == 1 || k == 4)) return "R6";
    if (wd && k == 1) return "R10";
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return (a[15] && (a & 16'h8700) == 16'h8100) ? "R3" : "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic wr, input logic wd, input logic [15:0] wdat);
    logic pass;
    int nb;
    logic [7:0] hi = 8'h00;
    logic [15:0] ba, exp_rsp;
    pass = wd && (kind(a) == 3) && (a[4:2] == 3'd0);
    nb = (wd && !pass) ? 2 : 1;
    @(negedge clk);
    // R11: idle between accesses
    chk({sel_rom, sel_scsi, sel_ide, sel_stat, rsp_valid} == 5'b0, "R11 idle",
        {sel_rom, sel_scsi, sel_ide, sel_stat, rsp_valid}, 0);
    bus_valid = 1'b1; bus_addr = a; bus_write = wr; bus_word = wd; bus_wdata = wdat;
    #1 chk(bus_ready == 1'b1, "R11 ready", bus_ready, 1);
    @(negedge clk);
    bus_valid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      logic [3:0]  es;
      logic [15:0] ew;
      int k;
      if (b == 1) @(negedge clk);
      ba = wd ? {a[15:1], b[0]} : a;
      k = kind(ba);
      es = {k == 1 && !wr, k == 2, k == 3, k == 4 && !wr};
      if (pass) ew = wdat;
      else if (wd && b == 0) ew = {8'h00, wdat[15:8]};
      else ew = {8'h00, wdat[7:0]};
      chk({sel_rom, sel_scsi, sel_ide, sel_stat} == es && out_addr == ba && out_write == wr &&
          out_word == pass && ide_reg == (k == 3 ? ba[4:2] : 3'd0) &&
          ide_chan == (k == 3 && ba[13]) && (!wr || out_wdata == ew),
          tag_of(ba, wr, wd, pass),
          {sel_rom, sel_scsi, sel_ide, sel_stat, out_addr, out_write, out_word, ide_reg, ide_chan, out_wdata},
          {es, ba, wr, pass, (k == 3 ? ba[4:2] : 3'd0), (k == 3 && ba[13]), ew});
      if (nb == 2 && b == 0) begin
        chk(bus_ready == 1'b0, "R11 stall", bus_ready, 0);
        hi = exp_byte(ba);
      end
    end
    if (!wr) begin
      if (pass) exp_rsp = ide_model(a);
      else if (wd) exp_rsp = {hi, exp_byte(ba)};
      else exp_rsp = {8'h00, exp_byte(a)};
      chk(rsp_valid && rsp_data == exp_rsp, wd && !pass ? "R9 rsp" : tag_of(a, wr, wd, pass),
          {rsp_valid, rsp_data}, {1'b1, exp_rsp});
    end else begin
      chk(!rsp_valid, "R6 no rsp on write", rsp_valid, 0);
    end
  endtask

  function automatic logic [15:0] rand_addr();
    logic [15:0] a = 16'($urandom);
    case ($urandom % 6)
      0: a[15] = 1'b0;
      1: begin a[15] = 1'b1; a[10:8] = ($urandom % 2) ? 3'b100 : 3'b000; end
      2: begin a[15] = 1'b1; a[10:8] = 3'b001; end
      3: begin a[15] = 1'b1; a[10:8] = 3'b011; end
      4: begin a[15] = 1'b1; a[10:8] = 3'b010 + 3'(($urandom % 2) * 3) + 3'(($urandom % 2) * 2); end
      default: ;
    endcase
    return a;
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R12: reset state
    chk({sel_rom, sel_scsi, sel_ide, sel_stat, rsp_valid, bus_ready} == 6'b000001, "R12",
        {sel_rom, sel_scsi, sel_ide, sel_stat, rsp_valid, bus_ready}, 1);
    rst_n = 1'b1;
    // directed
    cfg_dev_id = 3'd2; cfg_autoboot_en = 1'b1; cfg_opt0 = 1'b0;
    access(16'h1234, 1'b0, 1'b0, 16'h0);        // R1
    access(16'h0ABC, 1'b0, 1'b1, 16'h0);        // R10
    access(16'h0ABC, 1'b1, 1'b0, 16'h0055);     // R6 rom write
    access(16'h8000, 1'b1, 1'b0, 16'h0011);     // R2
    access(16'h8401, 1'b0, 1'b0, 16'h0);        // R2
    access(16'hA114, 1'b0, 1'b0, 16'h0);        // R3 secondary, idx 5
    access(16'h8115, 1'b0, 1'b0, 16'h0);        // R3 odd -> none
    access(16'h8100, 1'b1, 1'b1, 16'hBEEF);     // R8
    access(16'hA100, 1'b0, 1'b1, 16'h0);        // R8 secondary
    access(16'h810C, 1'b1, 1'b1, 16'hCAFE);     // R9 split, odd beat none
    access(16'h8300, 1'b0, 1'b0, 16'h0);        // R4
    ide0_irq = 1'b1;
    access(16'h8300, 1'b0, 1'b0, 16'h0);        // R5
    ide0_irq = 1'b0; ide0_drq = 1'b1; cfg_opt0 = 1'b1; cfg_autoboot_en = 1'b0;
    access(16'h8302, 1'b0, 1'b1, 16'h0);        // R5, R9
    access(16'h8300, 1'b1, 1'b0, 16'h0077);     // R6 status write
    access(16'h8500, 1'b0, 1'b0, 16'h0);        // R7
    access(16'h8700, 1'b0, 1'b1, 16'h0);        // R7 split
    // random
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic wd;
      cfg_dev_id = 3'($urandom); cfg_autoboot_en = 1'($urandom);
      cfg_opt0 = 1'($urandom); ide0_irq = 1'($urandom); ide0_drq = 1'($urandom);
      a = rand_addr();
      wd = 1'($urandom);
      if (wd) a[0] = 1'b0;
      access(a, 1'($urandom), wd, 16'($urandom));
    end
    @(negedge clk);
    chk({sel_rom, sel_scsi, sel_ide, sel_stat} == 4'b0, "R11 final idle",
        {sel_rom, sel_scsi, sel_ide, sel_stat}, 0);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule